// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This unit divides the system clock into time quanta and walks each nominal bit period through four segments: a one-quantum sync segment, a propagation segment, phase 1 and phase 2. At the end of phase 1 it reads the receive line and reports the bit value. In single mode it takes one sample. In triple mode it takes the majority of three samples spaced half a quantum apart. It also pulses a strobe at the start of every bit so the transmit side can launch its next bit.

The unit keeps its bit period aligned to the other nodes on the bus. It watches for falling edges (recessive to dominant) on the receive line. While the bus is idle, such an edge hard-restarts the bit. Otherwise the edge moves the sample point and bit end by an amount limited to the jump width. Framing, stuffing, CRC and arbitration belong to the controller around this unit.

The sampled bit leaves as a valid-only stream: `rx_bit_valid` qualifies `rx_bit` for one clock. There is no ready input, because bus timing cannot be stalled. A consumer must accept every beat in the cycle it is offered. All other pins are plain control pins. Configuration is expected to change only at a bit start. The receive line is assumed to be synchronous to `clk`.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2 × (`cfg_brp` + 1) clock cycles; with `cfg_brp` = 2 and the other fields set to prop 2, phase 1 3 and phase 2 3 quanta, a bit period is 54 clocks.
- R2: Each 3-bit segment field holding value n gives n + 1 quanta. The bit period is 1 + prop + phase1 + phase2 quanta. `bit_start` is a one-clock pulse in the first cycle of each sync segment.
- R3: `rx_bit_valid` is a one-clock pulse in the cycle after the last clock of phase 1, that is (1 + prop + phase1) quanta after `bit_start`. `rx_bit` holds the sampled value (1 = recessive, 0 = dominant) and resets to 1.
- R4: When `cfg_ph2_auto` = 1, phase 2 lasts max(phase1, 2) quanta and `cfg_ph2` is ignored.
- R5: When `cfg_triple` = 0, `rx_bit` is the line level at the sample clock only.
- R6: When `cfg_triple` = 1, `rx_bit` is the majority of the line at the sample clock, half a quantum earlier, and one quantum earlier.
- R7: A falling edge while `bus_idle` = 1 restarts the bit: `bit_start` pulses in the cycle after the edge is seen, and the quantum counter restarts.
- R8: After a hard restart, no falling edge adjusts timing for the rest of that bit.
- R9: A falling edge in the propagation segment or phase 1 is late. The phase error is the number of quanta since the end of sync, counting the current one. Phase 1 is lengthened by min(error, jump), where the 2-bit `cfg_sjw` value n gives a jump of n + 1 quanta.
- R10: A falling edge in phase 2 is early. The error is the number of phase-2 quanta left, counting the current one. If the error exceeds the jump, phase 2 is shortened by the jump. Otherwise the bit restarts at once, as in R7.
- R11: A falling edge inside the sync segment causes no adjustment.
- R12: Resynchronization happens at most once per bit, and only when the previous `rx_bit` was recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | Bus idle flag from the controller |
| cfg_brp | input | 6 | Prescale value minus one |
| cfg_prop | input | 3 | Propagation segment quanta minus one |
| cfg_ph1 | input | 3 | Phase 1 quanta minus one |
| cfg_ph2 | input | 3 | Phase 2 quanta minus one |
| cfg_sjw | input | 2 | Jump width quanta minus one |
| cfg_triple | input | 1 | 1 = three-sample majority |
| cfg_ph2_auto | input | 1 | 1 = phase 2 derived from phase 1 |
| rx_bit | output | 1 | Sampled bit value |
| rx_bit_valid | output | 1 | One-clock strobe qualifying `rx_bit` |
| bit_start | output | 1 | One-clock strobe at each sync segment start |

## Verification
Every cycle, the assertions check the following:
- each strobe is a single-clock pulse and each quantum tick is isolated;
- `bit_start` coincides with the first quantum of sync;
- a sample is always followed by phase 2;
- the stored stretch never exceeds the jump width;
- the stored shrink never consumes all of phase 2.

Only the directed scenarios can show the rest, because it depends on where an edge lands relative to the quanta:
- the exact clock counts from bit start to sample and to the next bit start under late, early and clipped edges;
- the blocking of edges after a hard restart or after a dominant bit;
- the majority vote against a short glitch.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int BRP_W_DEF = 6;
  localparam int SEG_W_DEF = 3;
  localparam int SJW_W_DEF = 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = cbt_pkg::BRP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic             restart,
  output logic             tq_tick,
  output logic             half_tick
);
  localparam int CNT_W = BRP_W + 1;

  logic [CNT_W-1:0] pcnt;
  logic [CNT_W-1:0] qmax;
  logic [CNT_W-1:0] half_pt;

  assign qmax      = {brp, 1'b1};
  assign half_pt   = {1'b0, brp};
  assign tq_tick   = (pcnt >= qmax);
  assign half_tick = tq_tick | (pcnt == half_pt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcnt <= '0;
    else if (restart || tq_tick) pcnt <= '0;
    else                         pcnt <= pcnt + 1'b1;
  end

  // R1: quantum ticks are never back to back
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic half_tick,
  input  logic smp_tick,
  input  logic triple,
  output logic bit_val,
  output logic bit_vld
);
  logic [1:0] hist;
  logic       vote;

  always_comb begin
    vote = (rx & hist[0]) | (rx & hist[1]) | (hist[0] & hist[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= 2'b11;
      bit_val <= 1'b1;
      bit_vld <= 1'b0;
    end else begin
      if (half_tick) hist <= {hist[0], rx};
      bit_vld <= smp_tick;
      if (smp_tick) bit_val <= triple ? vote : rx;
    end
  end

  // R3: the sample strobe lasts a single clock
  p_sample_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);
endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer #(
  parameter int SEG_W = cbt_pkg::SEG_W_DEF,
  parameter int SJW_W = cbt_pkg::SJW_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic             last_bit,
  input  logic [SEG_W-1:0] prop_f,
  input  logic [SEG_W-1:0] ph1_f,
  input  logic [SEG_W-1:0] ph2_f,
  input  logic [SJW_W-1:0] sjw_f,
  input  logic             ph2_auto,
  output logic             smp_tick,
  output logic             restart,
  output logic             bit_start
);
  import cbt_pkg::*;
  localparam int LEN_W = SEG_W + 2;

  seg_e             seg;
  logic [LEN_W-1:0] cnt, ext, shrink;
  logic             resync_done, rx_prev;

  logic [LEN_W-1:0] prop_len, ph1_base, ph2_len, sjw_len;
  logic [LEN_W-1:0] err, jump, ext_n, shrink_n, ph1_end, ph2_end, seg_last;
  logic             fall, hard, can_rs, early_rs, used_n;

  assign prop_len = LEN_W'(prop_f) + 1'b1;
  assign ph1_base = LEN_W'(ph1_f) + 1'b1;
  assign sjw_len  = LEN_W'(sjw_f) + 1'b1;
  assign ph2_len  = ph2_auto ? ((ph1_base > LEN_W'(2)) ? ph1_base : LEN_W'(2))
                             : LEN_W'(ph2_f) + 1'b1;

  assign fall   = rx_prev & ~rx;
  assign hard   = fall & bus_idle;
  assign can_rs = fall & ~bus_idle & ~resync_done & last_bit;

  always_comb begin
    case (seg)
      SEG_PROP: err = cnt + 1'b1;
      SEG_PH1:  err = prop_len + cnt + 1'b1;
      SEG_PH2:  err = ph2_len - cnt;
      default:  err = '0;
    endcase
    jump     = (err < sjw_len) ? err : sjw_len;
    ext_n    = ext;
    shrink_n = shrink;
    early_rs = 1'b0;
    used_n   = resync_done;
    if (can_rs) begin
      used_n = 1'b1;
      case (seg)
        SEG_PROP, SEG_PH1: ext_n = jump;
        SEG_PH2: begin
          if (err <= sjw_len) early_rs = 1'b1;
          else                shrink_n = jump;
        end
        default: ;
      endcase
    end
    ph1_end = ph1_base + ext_n - 1'b1;
    ph2_end = ph2_len - shrink_n - 1'b1;
    case (seg)
      SEG_SYNC: seg_last = '0;
      SEG_PROP: seg_last = prop_len - 1'b1;
      SEG_PH1:  seg_last = ph1_end;
      default:  seg_last = ph2_end;
    endcase
  end

  assign restart  = hard | early_rs;
  assign smp_tick = tq_tick & ~restart & (seg == SEG_PH1) & (cnt == ph1_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_SYNC;  cnt <= '0;  ext <= '0;  shrink <= '0;
      resync_done <= 1'b0;  rx_prev <= 1'b1;  bit_start <= 1'b0;
    end else begin
      rx_prev   <= rx;
      bit_start <= 1'b0;
      if (restart) begin
        seg <= SEG_SYNC;  cnt <= '0;  ext <= '0;  shrink <= '0;
        resync_done <= hard;
        bit_start   <= 1'b1;
      end else begin
        ext         <= ext_n;
        shrink      <= shrink_n;
        resync_done <= used_n;
        if (tq_tick) begin
          if (cnt == seg_last) begin
            cnt <= '0;
            case (seg)
              SEG_SYNC: seg <= SEG_PROP;
              SEG_PROP: seg <= SEG_PH1;
              SEG_PH1:  seg <= SEG_PH2;
              default: begin
                seg <= SEG_SYNC;  ext <= '0;  shrink <= '0;
                resync_done <= 1'b0;  bit_start <= 1'b1;
              end
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R2: a bit start is seen only in the first quantum of sync
  p_start_in_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> (seg == SEG_SYNC && cnt == '0));
  // R3: sampling closes phase 1
  p_sample_then_ph2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |=> (seg == SEG_PH2));
  // R9: stored stretch stays within the jump width
  p_ext_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext <= sjw_len);
  // R10: shrinking never removes all of phase 2
  p_shrink_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shrink < ph2_len);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = cbt_pkg::BRP_W_DEF,
  parameter int SEG_W = cbt_pkg::SEG_W_DEF,
  parameter int SJW_W = cbt_pkg::SJW_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             cfg_triple,
  input  logic             cfg_ph2_auto,
  output logic             rx_bit,
  output logic             rx_bit_valid,
  output logic             bit_start
);
  logic tq_tick, half_tick, smp_tick, restart;

  cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .brp(cfg_brp), .restart(restart),
    .tq_tick(tq_tick), .half_tick(half_tick));

  cbt_sequencer #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx(rx), .bus_idle(bus_idle),
    .last_bit(rx_bit), .prop_f(cfg_prop), .ph1_f(cfg_ph1), .ph2_f(cfg_ph2),
    .sjw_f(cfg_sjw), .ph2_auto(cfg_ph2_auto), .smp_tick(smp_tick),
    .restart(restart), .bit_start(bit_start));

  cbt_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .rx(rx), .half_tick(half_tick),
    .smp_tick(smp_tick), .triple(cfg_triple), .bit_val(rx_bit),
    .bit_vld(rx_bit_valid));

  // R2: bit start strobe lasts a single clock
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !bit_start);
endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, bus_idle = 1'b0;
  logic [5:0] cfg_brp = 6'd0;
  logic [2:0] cfg_prop = 3'd1, cfg_ph1 = 3'd2, cfg_ph2 = 3'd2;
  logic [1:0] cfg_sjw = 2'd0;
  logic cfg_triple = 1'b0, cfg_ph2_auto = 1'b0;
  logic rx_bit, rx_bit_valid, bit_start;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .rx(rx), .bus_idle(bus_idle),
    .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1),
    .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw), .cfg_triple(cfg_triple),
    .cfg_ph2_auto(cfg_ph2_auto), .rx_bit(rx_bit),
    .rx_bit_valid(rx_bit_valid), .bit_start(bit_start));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts at the negedge where bit_start is seen; returns at the next one.
  task automatic run_bit(input int fall_at, input int rise_at,
                         output int t_smp, output int t_end, output int sv);
    t_smp = -1; t_end = -1; sv = -1;
    for (int i = 1; i < 2000 && t_end < 0; i++) begin
      @(negedge clk);
      if (rx_bit_valid) begin t_smp = i; sv = int'(rx_bit); end
      if (bit_start) t_end = i;
      else begin
        if (i == fall_at) rx = 1'b0;
        if (i == rise_at) rx = 1'b1;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset bit_start", int'(bit_start), 0);
    chk("R3 reset valid", int'(rx_bit_valid), 0);
    chk("R3 reset rx_bit", int'(rx_bit), 1);
    for (int i = 0; i < 100 && !bit_start; i++) @(negedge clk);
  endtask

  task automatic t_nominal;
    int s, e, v;
    run_bit(-1, -1, s, e, v);
    chk("R3 sample time", s, 12);
    chk("R2 bit length", e, 18);
    chk("R3 sample value", v, 1);
  endtask

  task automatic t_late_and_block;
    int s, e, v;
    run_bit(2, -1, s, e, v);
    chk("R9 late prop stretch sample", s, 14);
    chk("R9 late prop stretch end", e, 20);
    run_bit(2, 1, s, e, v);
    chk("R12 prev dominant blocks", s, 12);
    chk("R12 prev dominant value", v, 0);
    run_bit(-1, 1, s, e, v);
    chk("R12 recovery value", v, 1);
  endtask

  task automatic t_jump_limit;
    int s, e, v;
    run_bit(8, -1, s, e, v);
    chk("R9 clipped to jump 1", s, 14);
    chk("R9 clipped end", e, 20);
    run_bit(-1, 1, s, e, v);
    cfg_sjw = 2'd1;
    run_bit(8, -1, s, e, v);
    chk("R9 clipped to jump 2", s, 16);
    chk("R9 jump 2 end", e, 22);
    cfg_sjw = 2'd0;
    run_bit(-1, 1, s, e, v);
  endtask

  task automatic t_early;
    int s, e, v;
    run_bit(12, -1, s, e, v);
    chk("R10 early shrink sample", s, 12);
    chk("R10 early shrink end", e, 16);
    run_bit(-1, 1, s, e, v);
    run_bit(16, -1, s, e, v);
    chk("R10 early restart end", e, 17);
    run_bit(-1, 1, s, e, v);
  endtask

  task automatic t_hard;
    int s, e, v;
    bus_idle = 1'b1;
    run_bit(5, -1, s, e, v);
    chk("R7 hard restart", e, 6);
    chk("R7 no sample before restart", s, -1);
    bus_idle = 1'b0;
    run_bit(3, 1, s, e, v);
    chk("R8 no resync after hard", s, 12);
    chk("R8 bit length after hard", e, 18);
    run_bit(-1, 1, s, e, v);
  endtask

  task automatic t_sync_edge;
    int s, e, v;
    run_bit(1, -1, s, e, v);
    chk("R11 sync edge sample", s, 12);
    chk("R11 sync edge end", e, 18);
  endtask

  task automatic t_majority;
    int s, e, v;
    run_bit(11, 9, s, e, v);
    chk("R5 single sample", v, 0);
    cfg_triple = 1'b1;
    run_bit(11, 9, s, e, v);
    chk("R6 triple majority", v, 1);
    cfg_triple = 1'b0;
    run_bit(-1, 1, s, e, v);
  endtask

  task automatic t_prescale;
    int s, e, v;
    cfg_brp = 6'd2;
    run_bit(-1, -1, s, e, v);
    chk("R1 prescale sample", s, 36);
    chk("R1 prescale bit", e, 54);
    cfg_brp = 6'd0;
  endtask

  task automatic t_auto;
    int s, e, v;
    cfg_ph2_auto = 1'b1; cfg_ph1 = 3'd4; cfg_ph2 = 3'd0;
    run_bit(-1, -1, s, e, v);
    chk("R4 auto long sample", s, 16);
    chk("R4 auto long bit", e, 26);
    cfg_ph1 = 3'd0;
    run_bit(-1, -1, s, e, v);
    chk("R4 auto short sample", s, 8);
    chk("R4 auto short bit", e, 12);
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_late_and_block();
    t_jump_limit();
    t_early();
    t_hard();
    t_sync_edge();
    t_majority();
    t_prescale();
    t_auto();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule